// File: doc/BRIEF.md
# I2C Register Target with 24-bit Addresses and Words

This block is an I2C target that lets a bus host read and write a register space where both the register address and the data word are 24 bits wide. The host first sends the target's device address with the write direction, then a three-byte register address, most significant byte first. For a write it continues with three data bytes, and the target commits them as one word. For a read it issues a repeated START and the read-direction device address, and the target returns the addressed word as three bytes, most significant byte first.

The top address byte (bits 23:16) selects an internal address space. The low 16 bits select a location within that space. Space 0 holds the processing parameters. The back end is a small synchronous register bank with `NUM_SPACES` spaces of `2**LOC_BITS` words each. The bus pins are sampled through a two-stage synchroniser on the system clock. SDA is driven open-drain through a single output-enable signal.

Top module: `i2c_reg24_target`

## Requirements
- R1: The target answers to the 7-bit address 0x59, which is bus byte 0xB2 for a write and 0xB3 for a read. It ACKs a matching address byte by pulling SDA low for the whole ninth clock.
- R2: A device address byte with any other 7-bit address is NACKed. The target then drives nothing and commits nothing until the next START.
- R3: After 0xB2 the target takes three register address bytes, bits 23:16 first, then 15:8, then 7:0, and ACKs each one.
- R4: After the register address, three data bytes (bits 23:16, 15:8, 7:0) are ACKed. At the falling SCL edge that ends the third data byte's ACK, `wr_en_o` pulses for exactly one clock with the assembled address and data.
- R5: A write cut short by STOP or START before the third data byte's ACK completes produces no strobe, and the addressed location keeps its old value.
- R6: A read transaction (START, 0xB2, three address bytes, repeated START, 0xB3) returns the stored word as three bytes, most significant byte first, with the target releasing SDA on every ninth clock.
- R7: The read word is latched when the 0xB3 byte is ACKed. After the host NACKs the third read byte, the target releases SDA. A STOP returns the target to idle with SDA released.
- R8: An address maps to storage only when bits 23:16 are below `NUM_SPACES` and bits 15:`LOC_BITS` are zero. Writes to any other address still raise the strobe but change no stored word, and reads of such an address return zero. Different spaces hold separate words.
- R9: A fourth data byte in a write is NACKed and produces no further strobe.
- R10: The target only ever pulls SDA low (active-high `sda_oe_o`). It changes `sda_oe_o` only while SCL is low.
- R11: After reset, `sda_oe_o` and `wr_en_o` are low and every location reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| wr_en_o | output | 1 | One-cycle write commit strobe |
| wr_addr_o | output | 24 | Register address of the committed write |
| wr_data_o | output | 24 | Data word of the committed write |

## Verification
The states are IDLE, RX_BIT (receive a byte), ACK_DRIVE (hold the ACK), TX_BIT (send a byte), MST_ACK (sample the host's acknowledge) and SKIP (ignore the bus). START moves any state to RX_BIT. STOP moves any state to IDLE. A received byte moves RX_BIT to ACK_DRIVE or to SKIP. ACK_DRIVE moves on to RX_BIT, TX_BIT or SKIP (after a commit). TX_BIT moves to MST_ACK. MST_ACK moves to TX_BIT or to SKIP.

The assertions check on every cycle that:
- the SDA drive holds still while SCL is high;
- the write strobe is a single-cycle pulse that leaves ACK_DRIVE;
- STOP leaves the target idle and released;
- SKIP never drives the bus;
- START always opens a new receive.

Only the bench scenarios can show the following, since each depends on whole byte sequences and on the stored contents:
- the right ACK and NACK pattern for matching, foreign and surplus bytes;
- MSB-first assembly of address and data;
- discarding of truncated writes;
- the mapping of spaces and out-of-range locations;
- read-back of written words.

// File: rtl/i2c_reg24_pkg.sv
package i2c_reg24_pkg;
    localparam int REG_AW = 24;
    localparam int REG_DW = 24;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX_BIT,
        S_ACK_DRIVE,
        S_TX_BIT,
        S_MST_ACK,
        S_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_REG,
        PH_DATA
    } phase_e;

    typedef enum logic [1:0] {
        NX_RX,
        NX_TX,
        NX_COMMIT
    } after_ack_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic scl_m1, scl_s_q, scl_d_q;
    logic sda_m1, sda_s_q, sda_d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m1  <= 1'b1;
            scl_s_q <= 1'b1;
            scl_d_q <= 1'b1;
            sda_m1  <= 1'b1;
            sda_s_q <= 1'b1;
            sda_d_q <= 1'b1;
        end else begin
            scl_m1  <= scl_i;
            scl_s_q <= scl_m1;
            scl_d_q <= scl_s_q;
            sda_m1  <= sda_i;
            sda_s_q <= sda_m1;
            sda_d_q <= sda_s_q;
        end
    end

    assign sda_s    = sda_s_q;
    assign scl_rise = scl_s_q & ~scl_d_q;
    assign scl_fall = ~scl_s_q & scl_d_q;
    assign start_p  = scl_s_q & scl_d_q & sda_d_q & ~sda_s_q;
    assign stop_p   = scl_s_q & scl_d_q & ~sda_d_q & sda_s_q;
endmodule

// File: rtl/reg24_bank.sv
module reg24_bank import i2c_reg24_pkg::*; #(
    parameter int NUM_SPACES = 4,
    parameter int LOC_BITS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [REG_DW-1:0] wdata,
    input  logic [REG_AW-1:0] raddr,
    output logic [REG_DW-1:0] rdata
);
    localparam int SPACE_BITS = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1;
    localparam int IDX_BITS   = SPACE_BITS + LOC_BITS;
    localparam int DEPTH      = 1 << IDX_BITS;

    logic [REG_DW-1:0] mem_q [DEPTH];
    logic              w_ok, r_ok;
    logic [IDX_BITS-1:0] w_idx, r_idx;

    assign w_ok  = (waddr[23:16] < 8'(NUM_SPACES)) && (waddr[15:LOC_BITS] == '0);
    assign r_ok  = (raddr[23:16] < 8'(NUM_SPACES)) && (raddr[15:LOC_BITS] == '0);
    assign w_idx = {waddr[16 +: SPACE_BITS], waddr[LOC_BITS-1:0]};
    assign r_idx = {raddr[16 +: SPACE_BITS], raddr[LOC_BITS-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rdata <= '0;
        end else begin
            if (we && w_ok) mem_q[w_idx] <= wdata;
            rdata <= r_ok ? mem_q[r_idx] : '0;
        end
    end
endmodule

// File: rtl/i2c_reg24_target.sv
module i2c_reg24_target import i2c_reg24_pkg::*; #(
    parameter logic [6:0] DEV_ADDR   = 7'h59,
    parameter int         NUM_SPACES = 4,
    parameter int         LOC_BITS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [REG_AW-1:0] wr_addr_o,
    output logic [REG_DW-1:0] wr_data_o
);
    logic sda_s, scl_rise, scl_fall, start_p, stop_p;

    tgt_state_e  state_q, state_d;
    phase_e      phase_q;
    after_ack_e  next_q;
    logic [3:0]  bit_cnt_q;
    logic [1:0]  byte_cnt_q, tx_idx_q;
    logic [7:0]  shift_q, tx_next;
    logic [REG_AW-1:0] addr_q;
    logic [REG_DW-1:0] data_q, rd_word_q, bank_rdata;
    logic        mack_q, byte_ok;

    i2c_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    reg24_bank #(.NUM_SPACES(NUM_SPACES), .LOC_BITS(LOC_BITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_en_o), .waddr(wr_addr_o),
        .wdata(wr_data_o), .raddr(addr_q), .rdata(bank_rdata)
    );

    // a received byte is accepted unless it is a foreign device address
    assign byte_ok = (phase_q != PH_DEV) || (shift_q[7:1] == DEV_ADDR);
    assign tx_next = (tx_idx_q == 2'd0) ? rd_word_q[15:8] : rd_word_q[7:0];

    always_comb begin
        state_d = state_q;
        if (stop_p) begin
            state_d = S_IDLE;
        end else if (start_p) begin
            state_d = S_RX_BIT;
        end else begin
            unique case (state_q)
                S_IDLE:      state_d = S_IDLE;
                S_RX_BIT:    if (scl_fall && bit_cnt_q == 4'd8)
                                 state_d = byte_ok ? S_ACK_DRIVE : S_SKIP;
                S_ACK_DRIVE: if (scl_fall) begin
                                 unique case (next_q)
                                     NX_TX:     state_d = S_TX_BIT;
                                     NX_COMMIT: state_d = S_SKIP;
                                     default:   state_d = S_RX_BIT;
                                 endcase
                             end
                S_TX_BIT:    if (scl_fall && bit_cnt_q == 4'd7) state_d = S_MST_ACK;
                S_MST_ACK:   if (scl_fall)
                                 state_d = (mack_q && tx_idx_q != 2'd2) ? S_TX_BIT : S_SKIP;
                S_SKIP:      state_d = S_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q    <= PH_DEV;
            next_q     <= NX_RX;
            bit_cnt_q  <= '0;
            byte_cnt_q <= '0;
            tx_idx_q   <= '0;
            shift_q    <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            rd_word_q  <= '0;
            mack_q     <= 1'b0;
            sda_oe_o   <= 1'b0;
            wr_en_o    <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (stop_p) begin
                sda_oe_o <= 1'b0;
            end else if (start_p) begin
                phase_q   <= PH_DEV;
                bit_cnt_q <= '0;
                sda_oe_o  <= 1'b0;
            end else begin
                unique case (state_q)
                    S_RX_BIT: begin
                        if (scl_rise) begin
                            shift_q   <= {shift_q[6:0], sda_s};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (scl_fall && bit_cnt_q == 4'd8 && byte_ok) begin
                            sda_oe_o <= 1'b1;
                            next_q   <= NX_RX;
                            unique case (phase_q)
                                PH_DEV: begin
                                    if (shift_q[0]) begin
                                        next_q    <= NX_TX;
                                        rd_word_q <= bank_rdata;
                                    end else begin
                                        phase_q    <= PH_REG;
                                        byte_cnt_q <= '0;
                                    end
                                end
                                PH_REG: begin
                                    addr_q <= {addr_q[15:0], shift_q};
                                    if (byte_cnt_q == 2'd2) begin
                                        phase_q    <= PH_DATA;
                                        byte_cnt_q <= '0;
                                    end else begin
                                        byte_cnt_q <= byte_cnt_q + 2'd1;
                                    end
                                end
                                default: begin
                                    data_q <= {data_q[15:0], shift_q};
                                    if (byte_cnt_q == 2'd2) next_q <= NX_COMMIT;
                                    else byte_cnt_q <= byte_cnt_q + 2'd1;
                                end
                            endcase
                        end
                    end
                    S_ACK_DRIVE: begin
                        if (scl_fall) begin
                            bit_cnt_q <= '0;
                            sda_oe_o  <= 1'b0;
                            if (next_q == NX_TX) begin
                                shift_q  <= rd_word_q[23:16];
                                sda_oe_o <= ~rd_word_q[23];
                                tx_idx_q <= '0;
                            end else if (next_q == NX_COMMIT) begin
                                wr_en_o   <= 1'b1;
                                wr_addr_o <= addr_q;
                                wr_data_o <= data_q;
                            end
                        end
                    end
                    S_TX_BIT: begin
                        if (scl_fall) begin
                            if (bit_cnt_q == 4'd7) begin
                                sda_oe_o <= 1'b0;
                            end else begin
                                sda_oe_o  <= ~shift_q[6];
                                shift_q   <= {shift_q[6:0], 1'b0};
                                bit_cnt_q <= bit_cnt_q + 4'd1;
                            end
                        end
                    end
                    S_MST_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                        end else if (scl_fall && mack_q && tx_idx_q != 2'd2) begin
                            shift_q   <= tx_next;
                            sda_oe_o  <= ~tx_next[7];
                            tx_idx_q  <= tx_idx_q + 2'd1;
                            bit_cnt_q <= '0;
                        end
                    end
                    default: sda_oe_o <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg24_checker.sv
module i2c_reg24_checker import i2c_reg24_pkg::*; (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_p,
    input logic       stop_p,
    input logic       sda_oe,
    input logic       wr_en,
    input tgt_state_e state
);
    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_p) && !$past(stop_p)) |-> $stable(sda_oe)); // R10

    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R4

    AST_STROBE_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> ($past(state) == S_ACK_DRIVE)); // R4

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (state == S_IDLE && !sda_oe)); // R7

    AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SKIP) |-> !sda_oe); // R2

    AST_START_LISTENS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p && !stop_p) |=> (state == S_RX_BIT)); // R1
endmodule

bind i2c_reg24_target i2c_reg24_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(u_sync.scl_s_q), .start_p(start_p),
    .stop_p(stop_p), .sda_oe(sda_oe_o), .wr_en(wr_en_o), .state(state_q)
);

// File: tb/i2c_reg24_target_tb_top.sv
module i2c_reg24_target_tb_top;
    localparam int Q   = 6;
    localparam int NSP = 4;
    localparam int LB  = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, wr_en;
    logic [23:0] wr_addr, wr_data;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_chk = 0, n_fail = 0, n_strobe = 0, n_viol = 0;
    logic [23:0] last_addr, last_data;
    logic [23:0] mem_m [64];
    logic prev_oe = 1'b0;

    always #4 clk = ~clk;

    i2c_reg24_target #(.DEV_ADDR(7'h59), .NUM_SPACES(NSP), .LOC_BITS(LB)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    always @(negedge clk) begin
        if (wr_en) begin
            n_strobe++;
            last_addr = wr_addr;
            last_data = wr_data;
        end
        if (rst_n && sda_oe !== prev_oe && scl_m) n_viol++;
        prev_oe = sda_oe;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic bit in_range(input logic [23:0] a);
        return (a[23:16] < 8'(NSP)) && (a[15:LB] == '0);
    endfunction

    function automatic logic [23:0] exp_word(input logic [23:0] a);
        if (!in_range(a)) return 24'h0;
        return mem_m[(int'(a[23:16]) << LB) + int'(a[LB-1:0])];
    endfunction

    function automatic void model_write(input logic [23:0] a, input logic [23:0] d);
        if (in_range(a)) mem_m[(int'(a[23:16]) << LB) + int'(a[LB-1:0])] = d;
    endfunction

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); scl_m = 1'b0; wq();
        end
        sda_m = last; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(); sda_m = 1'b1;
    endtask

    // ndata data bytes; end_rs ends with repeated START before STOP
    task automatic do_write(input logic [7:0] dev, input logic [23:0] a, input logic [31:0] d,
                            input int ndata, input bit end_rs, output logic [7:0] acks);
        logic ak;
        acks = '0;
        bus_start();
        send_byte(dev, ak); acks[0] = ak;
        for (int i = 0; i < 3; i++) begin
            send_byte(a[23 - 8*i -: 8], ak); acks[1+i] = ak;
        end
        for (int i = 0; i < ndata; i++) begin
            send_byte(d[31 - 8*(i + 4 - ndata) -: 8], ak); acks[4+i] = ak;
        end
        if (end_rs) bus_start();
        bus_stop();
    endtask

    task automatic do_read(input logic [23:0] a, output logic [23:0] d, output logic [4:0] acks);
        logic ak;
        logic [7:0] b;
        bus_start();
        send_byte(8'hB2, ak); acks[0] = ak;
        for (int i = 0; i < 3; i++) begin
            send_byte(a[23 - 8*i -: 8], ak); acks[1+i] = ak;
        end
        bus_start();
        send_byte(8'hB3, ak); acks[4] = ak;
        for (int i = 0; i < 3; i++) begin
            recv_byte(i == 2, b); d = {d[15:0], b};
        end
        bus_stop();
    endtask

    task automatic full_write(input logic [23:0] a, input logic [23:0] d, input string req);
        logic [7:0] acks;
        int s0;
        s0 = n_strobe;
        do_write(8'hB2, a, {8'h0, d}, 3, 1'b0, acks);
        check({req, " acks"}, {24'h0, acks}, 32'h7F);
        check({req, " strobe count"}, n_strobe - s0, 1);
        check({req, " strobe addr"}, {8'h0, last_addr}, {8'h0, a});
        check({req, " strobe data"}, {8'h0, last_data}, {8'h0, d});
        model_write(a, d);
    endtask

    task automatic read_chk(input logic [23:0] a, input string req);
        logic [23:0] d;
        logic [4:0] acks;
        do_read(a, d, acks);
        check({req, " read acks"}, {27'h0, acks}, 32'h1F);
        check({req, " read data"}, {8'h0, d}, {8'h0, exp_word(a)});
        check("R7 released after read", {31'h0, sda_oe}, 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] acks;
        int s0;
        for (int i = 0; i < 64; i++) mem_m[i] = '0;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 oe after reset", {31'h0, sda_oe}, 32'h0);
        check("R11 strobe after reset", {31'h0, wr_en}, 32'h0);
        read_chk(24'h000005, "R11 R1 R3 R6");

        full_write(24'h000003, 24'hA5C33C, "R1 R3 R4");
        read_chk(24'h000003, "R6");

        // R2: foreign address
        s0 = n_strobe;
        do_write(8'hB4, 24'h000003, 32'h00112233, 3, 1'b0, acks);
        check("R2 foreign acks", {24'h0, acks}, 32'h0);
        check("R2 no strobe", n_strobe - s0, 0);
        read_chk(24'h000003, "R2");

        // R5: truncated by STOP and by repeated START
        s0 = n_strobe;
        do_write(8'hB2, 24'h000003, 32'h00DEAD00, 2, 1'b0, acks);
        check("R5 stop acks", {24'h0, acks}, 32'h3F);
        check("R5 stop no strobe", n_strobe - s0, 0);
        do_write(8'hB2, 24'h000003, 32'h000000EE, 1, 1'b1, acks);
        check("R5 start no strobe", n_strobe - s0, 0);
        read_chk(24'h000003, "R5");

        // R8: spaces and range
        full_write(24'h020003, 24'h123456, "R8 space2");
        read_chk(24'h020003, "R8 space2");
        read_chk(24'h000003, "R8 space0 kept");
        full_write(24'h050001, 24'h777777, "R8 bad space");
        read_chk(24'h050001, "R8 bad space");
        full_write(24'h000101, 24'h888888, "R8 bad loc");
        read_chk(24'h000101, "R8 bad loc");
        read_chk(24'h000001, "R8 alias");

        // R9: fourth data byte
        s0 = n_strobe;
        do_write(8'hB2, 24'h03000F, 32'hCAFEF00D, 4, 1'b0, acks);
        check("R9 acks", {24'h0, acks}, 32'h7F);
        check("R9 one strobe", n_strobe - s0, 1);
        check("R9 strobe data", {8'h0, last_data}, 32'h00CAFEF0);
        model_write(24'h03000F, 24'hCAFEF0);
        read_chk(24'h03000F, "R9");

        for (int k = 0; k < 20; k++) begin
            logic [23:0] a, d;
            a = {8'($urandom_range(0, NSP)), 8'h0, 4'h0, 4'($urandom_range(0, 15))};
            if ($urandom_range(0, 7) == 0) a[8] = 1'b1;
            d = 24'($urandom);
            full_write(a, d, "R4 random");
            read_chk(a, "R6 random");
        end

        check("R10 SDA drive changed while SCL high", n_viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule